// File: doc/BRIEF.md
# Shared Peripheral Lock Register

This block is a single-bit hardware lock that lets several bus masters take turns owning one peripheral. Each master has its own register port with a read strobe, a write strobe, an address and an 8-bit data path. The lock lives in bit 0 of the status byte. A master claims the lock simply by reading that byte. If the read returns 0 in bit 0, that master now owns the peripheral, and the bit has already been set for everyone else. A master that reads a 1 must retry later. The owner gives the lock back by writing a byte with bit 0 set to the same address.

Bits 1 to 3 of the status byte carry three live status flags from the peripheral. They are returned with every status read. Read data comes back one cycle after the strobe and is marked by a per-port valid pulse. The ports have no back-pressure. Every strobe is accepted in the cycle it is presented, and the result cannot be stalled, so a master must take the returned byte in the cycle its valid pulse is high.

Top module: `hw_semaphore`

## Requirements
- R1: After reset the lock is free, `rvalid` and `rdata` are all zero, and the first status read returns 0 in bit 0.
- R2: A read strobe at the status address (default 0x8) that finds the lock free returns 0 in bit 0, and the lock is held from the next cycle on.
- R3: While the lock is held, every status read on any port returns 1 in bit 0.
- R4: A write strobe at the status address with data bit 0 = 1 frees the lock.
- R5: A write at the status address with data bit 0 = 0 leaves the lock unchanged.
- R6: A status read returns the `status_flags` input, as sampled in the strobe cycle, in bits 3:1, and zeros in bits 7:4.
- R7: Each read strobe on port p yields exactly one `rvalid[p]` pulse, in the cycle after the strobe, and `rvalid` is never high otherwise.
- R8: When several ports read the status address in the same cycle with the lock free, only the lowest-numbered of them gets 0 in bit 0, and all others get 1.
- R9: A read or write at any other address returns 0x00 (for reads) and neither takes nor frees the lock.
- R10: A release write and a status read in the same cycle act as release first, so the reader wins the free lock.
- R11: The lock goes from free to held only in a cycle that has a read strobe at the status address; write strobes never set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | NPORTS | Read strobe, one bit per port |
| wr_stb | input | NPORTS | Write strobe, one bit per port |
| addr | input | NPORTS*ADDR_W | Register address, port p at bits [p*ADDR_W +: ADDR_W] |
| wdata | input | NPORTS*8 | Write data, port p at bits [p*8 +: 8] |
| status_flags | input | 3 | Live peripheral flags returned in status bits 3:1 |
| rdata | output | NPORTS*8 | Read data, port p at bits [p*8 +: 8], valid with rvalid[p] |
| rvalid | output | NPORTS | One-cycle pulse marking read data on port p |

## Verification
There are two cases where one cycle holds more than one action. In the first, two ports claim the lock in the same cycle. The bench provokes this by pulsing both read strobes at the status address while the lock is free, and it requires port 0 to see 0 and port 1 to see 1. In the second, a release from one port coincides with a claim from another. The bench pairs a release write on port 1 with a status read on port 0 and expects port 0 to win. In both cases the follow-up reads must still see the lock held.

// File: rtl/sema_pkg.sv
package sema_pkg;

  // Layout of the status byte; bit 0 position is decoded by software.
  typedef struct packed {
    logic [3:0] zero;
    logic [2:0] flags;
    logic       held;
  } sema_status_t;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned FLAG_W = 3;

endpackage

// File: rtl/sema_port_decode.sv
module sema_port_decode #(
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(8)
) (
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              rd_lock,
  output logic              rel
);
  logic hit;
  logic unused_wbits;

  assign hit          = (addr == LOCK_ADDR);
  assign rd_lock      = rd & hit;
  assign rel          = wr & hit & wdata[0];
  assign unused_wbits = ^wdata[7:1];
endmodule

// File: rtl/sema_grant.sv
module sema_grant #(
  parameter int unsigned NPORTS = 2
) (
  input  logic [NPORTS-1:0] req,
  input  logic              free,
  output logic [NPORTS-1:0] win
);
  // Fixed priority: lowest port index claims a free lock.
  always_comb begin
    logic taken;
    taken = 1'b0;
    win   = '0;
    for (int p = 0; p < NPORTS; p++) begin
      win[p] = free & req[p] & ~taken;
      taken  = taken | win[p];
    end
  end
endmodule

// File: rtl/sema_lock_bit.sv
module sema_lock_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic rel_any,
  input  logic acq_any,
  output logic free_now,
  output logic lock_q
);
  logic lock_eff;

  // Release is applied before a same-cycle claim.
  assign lock_eff = lock_q & ~rel_any;
  assign free_now = ~lock_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_eff | acq_any;
  end
endmodule

// File: rtl/sema_readback.sv
module sema_readback
  import sema_pkg::*;
#(
  parameter int unsigned NPORTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    rd,
  input  logic [NPORTS-1:0]    rd_lock,
  input  logic [NPORTS-1:0]    win,
  input  logic [FLAG_W-1:0]    flags,
  output logic [NPORTS*DATA_W-1:0] rdata,
  output logic [NPORTS-1:0]    rvalid
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    sema_status_t stat;
    always_comb begin
      stat       = '0;
      stat.flags = flags;
      stat.held  = ~win[p];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rvalid[p]                   <= 1'b0;
        rdata[p*DATA_W +: DATA_W]   <= '0;
      end else begin
        rvalid[p] <= rd[p];
        if (rd[p])
          rdata[p*DATA_W +: DATA_W] <= rd_lock[p] ? stat : '0;
      end
    end
  end
endmodule

// File: rtl/hw_semaphore.sv
module hw_semaphore
  import sema_pkg::*;
#(
  parameter int unsigned NPORTS = 2,
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(8)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS-1:0]        rd_stb,
  input  logic [NPORTS-1:0]        wr_stb,
  input  logic [NPORTS*ADDR_W-1:0] addr,
  input  logic [NPORTS*8-1:0]      wdata,
  input  logic [2:0]               status_flags,
  output logic [NPORTS*8-1:0]      rdata,
  output logic [NPORTS-1:0]        rvalid
);
  logic [NPORTS-1:0] rd_lock;
  logic [NPORTS-1:0] rel;
  logic [NPORTS-1:0] win;
  logic              free_now;
  logic              lock_q;

  for (genvar p = 0; p < NPORTS; p++) begin : g_dec
    sema_port_decode #(.ADDR_W(ADDR_W), .LOCK_ADDR(LOCK_ADDR)) u_dec (
      .rd      (rd_stb[p]),
      .wr      (wr_stb[p]),
      .addr    (addr[p*ADDR_W +: ADDR_W]),
      .wdata   (wdata[p*8 +: 8]),
      .rd_lock (rd_lock[p]),
      .rel     (rel[p])
    );
  end

  sema_lock_bit u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .rel_any  (|rel),
    .acq_any  (|rd_lock),
    .free_now (free_now),
    .lock_q   (lock_q)
  );

  sema_grant #(.NPORTS(NPORTS)) u_grant (
    .req  (rd_lock),
    .free (free_now),
    .win  (win)
  );

  sema_readback #(.NPORTS(NPORTS)) u_rb (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (rd_stb),
    .rd_lock (rd_lock),
    .win     (win),
    .flags   (status_flags),
    .rdata   (rdata),
    .rvalid  (rvalid)
  );
endmodule

// File: rtl/sema_checker.sv
module sema_checker #(
  parameter int unsigned NPORTS = 2,
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(8)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NPORTS-1:0]        rd_stb,
  input logic [NPORTS-1:0]        wr_stb,
  input logic [NPORTS*ADDR_W-1:0] addr,
  input logic [NPORTS*8-1:0]      wdata,
  input logic [NPORTS*8-1:0]      rdata,
  input logic [NPORTS-1:0]        rvalid,
  input logic                     lock_q
);
  logic [NPORTS-1:0] c_rd_lock;
  logic [NPORTS-1:0] c_rel;
  logic [NPORTS-1:0] c_rd_lock_q;
  logic [NPORTS-1:0] zero_won;
  logic              unused_w;

  always_comb begin
    unused_w = 1'b0;
    for (int p = 0; p < NPORTS; p++) begin
      c_rd_lock[p] = rd_stb[p] && (addr[p*ADDR_W +: ADDR_W] == LOCK_ADDR);
      c_rel[p]     = wr_stb[p] && (addr[p*ADDR_W +: ADDR_W] == LOCK_ADDR) && wdata[p*8];
      zero_won[p]  = rvalid[p] && c_rd_lock_q[p] && !rdata[p*8];
      unused_w     = unused_w ^ (^wdata[p*8+1 +: 7]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) c_rd_lock_q <= '0;
    else        c_rd_lock_q <= c_rd_lock;
  end

  assert_single_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(zero_won) <= 1);

  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|c_rel) && !(|c_rd_lock)) |=> !lock_q);

  assert_keep_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !(|c_rel)) |=> lock_q);

  assert_read_only_acquire_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && !(|c_rd_lock)) |=> !lock_q);

  for (genvar p = 0; p < NPORTS; p++) begin : g_prt
    assert_rvalid_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb[p] |=> rvalid[p]);
    assert_rvalid_needs_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb[p] |=> !rvalid[p]);
    assert_held_reads_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !(|c_rel) && c_rd_lock[p]) |=> rdata[p*8]);
    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid[p] |-> (rdata[p*8+4 +: 4] == 4'h0));
  end
endmodule

bind hw_semaphore sema_checker #(
  .NPORTS(NPORTS), .ADDR_W(ADDR_W), .LOCK_ADDR(LOCK_ADDR)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rd_stb (rd_stb),
  .wr_stb (wr_stb),
  .addr   (addr),
  .wdata  (wdata),
  .rdata  (rdata),
  .rvalid (rvalid),
  .lock_q (lock_q)
);

// File: tb/hw_semaphore_test.sv
`timescale 1ns/1ps
module hw_semaphore_test;
  localparam int NP = 2;
  localparam int AW = 4;
  localparam logic [AW-1:0] LA = 4'h8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] rd_stb = '0;
  logic [NP-1:0] wr_stb = '0;
  logic [NP*AW-1:0] addr = '0;
  logic [NP*8-1:0]  wdata = '0;
  logic [2:0]    status_flags = 3'b000;
  logic [NP*8-1:0]  rdata;
  logic [NP-1:0] rvalid;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;
  bit tb_lock = 0;

  typedef struct { int port; int due; logic [7:0] val; string tag; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hw_semaphore #(.NPORTS(NP), .ADDR_W(AW), .LOCK_ADDR(LA)) uut (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb), .addr(addr),
    .wdata(wdata), .status_flags(status_flags), .rdata(rdata), .rvalid(rvalid)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Driver: one bus cycle, expected results pushed to the scoreboard.
  task automatic step(input logic [NP-1:0] rd, input logic [NP-1:0] wr,
                      input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                      input logic [7:0] d0, input logic [7:0] d1,
                      input logic [2:0] fl, input string tag);
    logic [AW-1:0] a [NP];
    logic [7:0]    d [NP];
    bit eff, taken, anyrd;
    @(negedge clk);
    a[0] = a0; a[1] = a1; d[0] = d0; d[1] = d1;
    rd_stb = rd; wr_stb = wr; addr = {a1, a0}; wdata = {d1, d0}; status_flags = fl;
    eff = tb_lock;
    for (int p = 0; p < NP; p++)
      if (wr[p] && a[p] == LA && d[p][0]) eff = 0;
    taken = 0; anyrd = 0;
    for (int p = 0; p < NP; p++) begin
      if (rd[p]) begin
        exp_t e;
        e.port = p; e.due = cyc + 1; e.tag = tag;
        if (a[p] == LA) begin
          anyrd = 1;
          e.val = {4'h0, fl, (!eff && !taken) ? 1'b0 : 1'b1};
          if (!eff) taken = 1;
        end else e.val = 8'h00;
        sb.push_back(e);
      end
    end
    tb_lock = eff | anyrd;
  endtask

  task automatic idle();
    step('0, '0, 4'h0, 4'h0, 8'h00, 8'h00, status_flags, "idle");
  endtask

  // Monitor: compare results against the scoreboard (R7 timing).
  always @(negedge clk) begin
    if (rst_n) begin
      logic [NP-1:0] m;
      m = '0;
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        exp_t e;
        e = sb.pop_front();
        m[e.port] = 1'b1;
        if (!rvalid[e.port]) check(0, {e.tag, " R7 missing rvalid"}, 8'h00, e.val);
        else check(rdata[e.port*8 +: 8] == e.val, e.tag, rdata[e.port*8 +: 8], e.val);
      end
      for (int p = 0; p < NP; p++)
        if (rvalid[p] && !m[p]) check(0, "R7 unexpected rvalid", rdata[p*8 +: 8], 8'h00);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rvalid == '0, "R1 reset rvalid", {6'h0, rvalid}, 8'h00);
    check(rdata == '0, "R1 reset rdata", rdata[7:0] | rdata[15:8], 8'h00);
    rst_n = 1'b1;
    idle();
    // R1/R2: first read wins, flags in bits 3:1 (R6)
    step(2'b01, 2'b00, LA, 4'h0, 0, 0, 3'b101, "R1 R2 R6 first read");
    step(2'b10, 2'b00, 4'h0, LA, 0, 0, 3'b010, "R3 held other port");
    step(2'b01, 2'b00, LA, 4'h0, 0, 0, 3'b111, "R3 held owner");
    // R5: write zero keeps lock
    step(2'b00, 2'b01, LA, 4'h0, 8'hFE, 0, 3'b000, "R5 write");
    step(2'b10, 2'b00, 4'h0, LA, 0, 0, 3'b000, "R5 still held");
    // R9: release-looking write to other address ignored
    step(2'b00, 2'b10, 4'h0, 4'h4, 0, 8'h01, 3'b001, "R9 write other");
    step(2'b01, 2'b00, LA, 4'h0, 0, 0, 3'b001, "R9 still held");
    // R4: release then other port wins
    step(2'b00, 2'b01, LA, 4'h0, 8'h01, 0, 3'b001, "R4 release");
    step(2'b10, 2'b00, 4'h0, LA, 0, 0, 3'b100, "R4 reacquire");
    // R8: simultaneous claim
    step(2'b00, 2'b10, 4'h0, LA, 0, 8'hFF, 3'b000, "R4 release2");
    step(2'b11, 2'b00, LA, LA, 0, 0, 3'b011, "R8 tie");
    step(2'b11, 2'b00, LA, LA, 0, 0, 3'b011, "R8 after tie");
    // R10: release and claim in same cycle
    step(2'b01, 2'b10, LA, LA, 0, 8'h01, 3'b110, "R10 rel+read");
    step(2'b10, 2'b00, 4'h0, LA, 0, 0, 3'b110, "R10 held after");
    // R9: reads elsewhere return zero and do not acquire
    step(2'b00, 2'b01, LA, 4'h0, 8'h01, 0, 3'b000, "R9 release");
    step(2'b11, 2'b00, 4'h3, 4'hF, 0, 0, 3'b111, "R9 read other");
    // R11: writes never acquire
    step(2'b00, 2'b11, LA, LA, 8'h00, 8'h02, 3'b000, "R11 write zero");
    step(2'b10, 2'b00, 4'h0, LA, 0, 0, 3'b010, "R11 R9 still free");
    idle(); idle(); idle();
    check(sb.size() == 0, "R7 leftover expectations", 8'(sb.size()), 8'h00);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 8'h00, 8'h00);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule